// File: doc/BRIEF.md
# Multi-Port General-Purpose I/O Bank

This block gives a small 8-bit processor a bank of general-purpose I/O ports. Each port has two parts:

- an output data latch, written from the CPU data bus;
- a write-only direction latch, loaded from the working register by its own strobe.

A direction bit of 0 enables the output driver for that pin, so the pin carries the latched data. A direction bit of 1 turns the driver off, and the pin is an input. Every pin is set independently. On the pad side, each pin has an output value, an output enable and a sampled input.

A read of a port never returns the data latch. It returns the pin levels as seen through a two-flop synchronizer and a registered read bus. Each port is built in one of three shapes: a full byte, the low nibble only, or the high nibble only. Bits that a shape leaves out have no latches, never drive and always read as zero. Addresses that select no port read as zero, and writes to them are ignored.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every output enable is 0, so all pins are inputs. The read bus is 0 while reset is asserted.
- R2: Bit i of port p uses pad bit 8p+i. Its output enable is 1 exactly when direction bit i of that port is 0, and then pin_out carries data latch bit i. Each bit is controlled independently of the others.
- R3: A direction latch changes only on a clock where cpu_dir_ld is high and cpu_addr selects its port. It then takes the value of cpu_acc. Data writes leave it unchanged.
- R4: A read returns the pin input levels, never the data latch. A pin that is driven high but held low outside reads 0.
- R5: With the address held, a change on pin_in that is set up before a clock edge appears on cpu_rdata after the third rising edge. After the second edge the old value is still shown.
- R6: A data latch keeps its value until its own port is written with cpu_wr. Writes to other ports do not change it.
- R7: A data write updates the latch even when the pins are inputs. The stored value appears on pin_out once the direction bits are cleared.
- R8: The low-nibble port at address 0 implements bits 3:0 only. Bits 7:4 read 0, never drive, and keep pin_out at 0.
- R9: The high-nibble port at address 4 implements bits 7:4 only. Bits 3:0 read 0, never drive, and keep pin_out at 0.
- R10: Addresses 5 to 7 select no port. Reads there return 0, and writes or direction loads there change no pin output or output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Port select |
| cpu_wr | input | 1 | Write strobe for the selected data latch |
| cpu_wdata | input | 8 | Data written to the data latch |
| cpu_dir_ld | input | 1 | Load strobe for the selected direction latch |
| cpu_acc | input | 8 | Working-register value for direction loads |
| cpu_rdata | output | 8 | Registered, synchronized pin levels of the selected port |
| pin_in | input | 40 | Pad input levels, port p at bits 8p+7:8p |
| pin_out | output | 40 | Pad output values |
| pin_oe | output | 40 | Pad output enables, 1 drives |

## Verification
A table of reads drives different byte patterns onto each port shape and onto the unmapped addresses. It separates full ports from nibble ports, and nibble ports from each other, by which half survives. Directed sequences then use three patterns:

- Mixed-nibble direction patterns show that each bit is controlled on its own.
- A latch value that differs from the driven pin level shows that reads come from the pins.
- A step on the pins, sampled after two and after three edges, pins the read latency exactly.

Writes made while the pins are inputs, and writes to other ports or to empty addresses, show that the latches are isolated from each other.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;

  typedef enum logic [1:0] {
    SHAPE_FULL = 2'd0,
    SHAPE_LOW  = 2'd1,
    SHAPE_HIGH = 2'd2
  } shape_e;

  function automatic logic [DATA_W-1:0] shape_mask(input logic [1:0] s);
    logic [DATA_W-1:0] m;
    case (s)
      SHAPE_LOW:  m = {{NIB_W{1'b0}}, {NIB_W{1'b1}}};
      SHAPE_HIGH: m = {{NIB_W{1'b1}}, {NIB_W{1'b0}}};
      default:    m = {DATA_W{1'b1}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    stab_q <= meta_q;
  end
  assign q = stab_q;

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)              age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R5: the synchronizer output lags its input by exactly two clocks
  a_r5_two_stage: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter logic [1:0] SHAPE = SHAPE_FULL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              dir_ld,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam logic [DATA_W-1:0] MASK = shape_mask(SHAPE);

  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (sel && wr) data_q <= wdata & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)                dir_q <= {DATA_W{1'b1}};
    else if (sel && dir_ld) dir_q <= acc | ~MASK;
  end

  assign pin_out = data_q & MASK;
  assign pin_oe  = ~dir_q & MASK;

  // R1: the first cycle after reset has every driver off
  a_r1_reset_inputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0));
  // R3: enables move only on a direction load aimed at this port
  a_r3_dir_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !(sel && dir_ld) |=> $stable(pin_oe));
  // R6: output values move only on a data write aimed at this port
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr) |=> $stable(pin_out));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux #(
  parameter int NPORTS = 5,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    sel,
  input  logic [NPORTS*DW-1:0] bus,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (sel[p]) pick = pick | bus[p*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= pick;
  end

  // R10: an address that selects no port reads back zero
  a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == '0) |-> (rdata == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int              NPORTS = 5,
  parameter int              ADDR_W = 3,
  parameter logic [2*NPORTS-1:0] SHAPES = {SHAPE_HIGH, SHAPE_FULL, SHAPE_FULL, SHAPE_FULL, SHAPE_LOW}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic                     cpu_wr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic                     cpu_dir_ld,
  input  logic [DATA_W-1:0]        cpu_acc,
  output logic [DATA_W-1:0]        cpu_rdata,
  input  logic [NPORTS*DATA_W-1:0] pin_in,
  output logic [NPORTS*DATA_W-1:0] pin_out,
  output logic [NPORTS*DATA_W-1:0] pin_oe
);
  localparam int PINS = NPORTS * DATA_W;

  logic [NPORTS-1:0] sel;
  logic [PINS-1:0]   impl_mask;
  logic [PINS-1:0]   pins_synced;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [1:0] SH = SHAPES[2*p +: 2];
    assign sel[p] = (cpu_addr == ADDR_W'(p));
    assign impl_mask[p*DATA_W +: DATA_W] = shape_mask(SH);

    gpio_port #(.SHAPE(SH)) i_port (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel[p]),
      .wr      (cpu_wr),
      .dir_ld  (cpu_dir_ld),
      .wdata   (cpu_wdata),
      .acc     (cpu_acc),
      .pin_out (pin_out[p*DATA_W +: DATA_W]),
      .pin_oe  (pin_oe[p*DATA_W +: DATA_W])
    );
  end

  gpio_sync #(.W(PINS)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in & impl_mask),
    .q   (pins_synced)
  );

  gpio_rdmux #(.NPORTS(NPORTS), .DW(DATA_W)) i_rdmux (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .bus   (pins_synced),
    .rdata (cpu_rdata)
  );
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {addr[2:0], pin byte[7:0], expected read[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'hA5, 8'h05}, {3'd4, 8'hA5, 8'hA0}, {3'd1, 8'h3C, 8'h3C},
    {3'd2, 8'hFF, 8'hFF}, {3'd3, 8'h00, 8'h00}, {3'd5, 8'hFF, 8'h00},
    {3'd7, 8'h12, 8'h00}, {3'd0, 8'hFF, 8'h0F}, {3'd4, 8'h0F, 8'h00},
    {3'd2, 8'h81, 8'h81}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_dir_ld = 1'b0;
  logic [7:0]  cpu_acc = '0;
  logic [7:0]  cpu_rdata;
  logic [39:0] pin_in = '0;
  logic [39:0] pin_out;
  logic [39:0] pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_dir_ld(cpu_dir_ld), .cpu_acc(cpu_acc),
    .cpu_rdata(cpu_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_data(input logic [2:0] a, input logic [7:0] v);
    cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic ld_dir(input logic [2:0] a, input logic [7:0] v);
    cpu_addr = a; cpu_acc = v; cpu_dir_ld = 1'b1;
    @(negedge clk);
    cpu_dir_ld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [39:0] snap_out, snap_oe;
    edges(3);
    // R1: reset state
    chk("R1 oe in reset", pin_oe, 40'h0);
    chk("R1 rdata in reset", {32'h0, cpu_rdata}, 40'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, 40'h0);

    // Table walk: R4, R8, R9, R10 read shapes
    for (int v = 0; v < NV; v++) begin
      logic [2:0] a;
      a = VEC[v][18:16];
      if (a < 3'd5) begin
        pin_in = '0;
        pin_in[a*8 +: 8] = VEC[v][15:8];
      end else begin
        pin_in = {5{VEC[v][15:8]}};
      end
      cpu_addr = a;
      edges(3);
      chk("R4/R8/R9/R10 table read", {32'h0, cpu_rdata}, {32'h0, VEC[v][7:0]});
    end
    pin_in = '0;

    // R2, R3: per-bit direction on port 1
    ld_dir(3'd1, 8'hF0);
    chk("R2 mixed direction", {32'h0, pin_oe[15:8]}, 40'h0F);
    wr_data(3'd1, 8'h5A);
    chk("R3 data write keeps direction", {32'h0, pin_oe[15:8]}, 40'h0F);
    chk("R2 output follows latch", {32'h0, pin_out[15:8]}, 40'h5A);
    ld_dir(3'd1, 8'h00);
    chk("R2 all drive", {32'h0, pin_oe[15:8]}, 40'hFF);

    // R6: write elsewhere, latch of port 1 holds
    wr_data(3'd2, 8'h33);
    edges(2);
    chk("R6 latch persists", {32'h0, pin_out[15:8]}, 40'h5A);

    // R4: driven latch 5A but pins held low externally
    pin_in[15:8] = 8'h00;
    cpu_addr = 3'd1;
    edges(4);
    chk("R4 read shows pins not latch", {32'h0, cpu_rdata}, 40'h00);

    // R5: latency of a pin step
    pin_in[15:8] = 8'hFF;
    edges(2);
    chk("R5 old value after two edges", {32'h0, cpu_rdata}, 40'h00);
    edges(1);
    chk("R5 new value after three edges", {32'h0, cpu_rdata}, 40'hFF);

    // R7: write while input, then enable
    ld_dir(3'd3, 8'hFF);
    wr_data(3'd3, 8'hC3);
    chk("R7 still input", {32'h0, pin_oe[31:24]}, 40'h00);
    ld_dir(3'd3, 8'h00);
    chk("R7 stored value drives", {32'h0, pin_out[31:24]}, 40'hC3);
    chk("R7 enabled", {32'h0, pin_oe[31:24]}, 40'hFF);

    // R8: low-nibble port
    ld_dir(3'd0, 8'h00);
    wr_data(3'd0, 8'hFF);
    chk("R8 oe low nibble only", {32'h0, pin_oe[7:0]}, 40'h0F);
    chk("R8 out low nibble only", {32'h0, pin_out[7:0]}, 40'h0F);

    // R9: high-nibble port
    ld_dir(3'd4, 8'h00);
    wr_data(3'd4, 8'hFF);
    chk("R9 oe high nibble only", {32'h0, pin_oe[39:32]}, 40'hF0);
    chk("R9 out high nibble only", {32'h0, pin_out[39:32]}, 40'hF0);

    // R10: empty address has no effect
    snap_out = pin_out;
    snap_oe = pin_oe;
    ld_dir(3'd6, 8'hAA);
    wr_data(3'd6, 8'h55);
    edges(1);
    chk("R10 out unchanged", pin_out, snap_out);
    chk("R10 oe unchanged", pin_oe, snap_oe);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule